// File: doc/BRIEF.md
# Nonvolatile Write Cycle Controller

This controller sits between a serial bus front end and a bank of per-channel registers. Each channel holds one volatile wiper register and a small set of nonvolatile data registers. The bus front end passes decoded write requests to the controller over a valid/ready stream. Each request carries a channel, a register select, a volatile/nonvolatile flag and a data byte. The front end also signals the bus START, STOP and abort events as one-cycle pulses.

A volatile write takes effect at once. A nonvolatile write is only held as pending, and it is committed only when the STOP that closes the transaction arrives. At that point the controller runs a timed internal programming cycle, whose length is set by a parameter in clock cycles. It raises `busy` for the whole cycle so that the bus side can refuse its address during acknowledge polling. The write-protect pin (`wp_n`, active low) blocks nonvolatile programming. It is checked only up to the start of the cycle and is ignored once the cycle is running.

Stream rules: a request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for exactly the cycles in which `busy` is high. While it is low, the source may hold `req_valid` with stable payload, and nothing is taken. Parameters must satisfy `CH` ≥ 2 and a power of two, `NVR` a power of two ≥ 2, and `PROG_CYCLES` ≥ 1.

Top module: `nv_write_ctrl`

## Requirements
- R1: An accepted request with `req_nv`=0 writes `req_data` into the wiper of `req_chan`, visible on `wiper_bus[chan*DW +: DW]` after that same clock edge. It raises no busy period, and `wp_n` has no effect on it.
- R2: An accepted request with `req_nv`=1 changes no register and leaves `busy` low for as long as no STOP arrives.
- R3: A `bus_stop` pulse with a nonvolatile write pending and `wp_n` high makes `busy` go high after that edge and stay high for exactly `PROG_CYCLES` cycles. The target register takes the data at the same edge where `busy` falls, and not earlier.
- R4: While `busy` is high, `req_ready` is low and an offered request, volatile or not, is not taken and changes nothing.
- R5: A nonvolatile request accepted while `wp_n` is low is discarded: the following STOP starts no cycle and the target is unchanged.
- R6: `wp_n` low in any cycle from acceptance up to and including the STOP cycle cancels the pending write.
- R7: `wp_n` going low after the cycle has started has no effect: the cycle runs its full length and commits.
- R8: A `bus_start` or `bus_abort` pulse before the STOP discards a pending nonvolatile write.
- R9: With two nonvolatile requests in one transaction, the later one replaces the earlier. Only the later target is programmed, in a single cycle.
- R10: `req_sel` (`rd_sel`) picks one of `NVR` nonvolatile registers of a channel, value k addressing register k. Programming one register leaves every other register of every channel unchanged.
- R11: After reset all wipers and nonvolatile registers read zero, `busy` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | One-cycle pulse: START seen on the bus |
| bus_stop | input | 1 | One-cycle pulse: STOP seen on the bus |
| bus_abort | input | 1 | One-cycle pulse: transaction abandoned |
| wp_n | input | 1 | Write protect, low blocks nonvolatile programming |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Controller can take a request |
| req_nv | input | 1 | 1 = nonvolatile data register, 0 = volatile wiper |
| req_chan | input | $clog2(CH) | Channel select |
| req_sel | input | $clog2(NVR) | Nonvolatile register select |
| req_data | input | DW | Write data |
| busy | output | 1 | Programming cycle in progress |
| rd_chan | input | $clog2(CH) | Read channel for nonvolatile readback |
| rd_sel | input | $clog2(NVR) | Read register for nonvolatile readback |
| rd_data | output | DW | Selected nonvolatile register contents |
| wiper_bus | output | CH*DW | All wiper registers, channel 0 in the low bits |

## Verification
The main function is tried with a vector table. It mixes volatile and nonvolatile writes on different channels and selects, with write protect held high, held low at acceptance, or pulsed low between acceptance and STOP. The measured busy length and final register values separate a committed write from a discarded one. Directed sequences probe the timing and the cancel paths. A long gap before STOP shows nothing commits early. The cycle-by-cycle busy trace shows the register changes exactly when busy falls. Write protect dropped inside the cycle, a second START, an abort, two writes in one transaction and write protect low in the STOP cycle each separate the cancel paths from the commit path.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic {
    PEND_EMPTY = 1'b0,
    PEND_HELD  = 1'b1
  } pend_state_e;
endpackage

// File: rtl/nvc_pending.sv
module nvc_pending
  import nvc_pkg::*;
#(
  parameter int CH_W  = 2,
  parameter int SEL_W = 2,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             bus_abort,
  input  logic             wp_n,
  input  logic             busy,
  input  logic             cap,
  input  logic [CH_W-1:0]  cap_chan,
  input  logic [SEL_W-1:0] cap_sel,
  input  logic [DW-1:0]    cap_data,
  output logic             launch,
  output logic [CH_W-1:0]  l_chan,
  output logic [SEL_W-1:0] l_sel,
  output logic [DW-1:0]    l_data
);
  pend_state_e st;

  assign launch = (st == PEND_HELD) && bus_stop && wp_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PEND_EMPTY;
      l_chan <= '0;
      l_sel  <= '0;
      l_data <= '0;
    end else if (!wp_n) begin
      st <= PEND_EMPTY;
    end else if (cap) begin
      st     <= PEND_HELD;
      l_chan <= cap_chan;
      l_sel  <= cap_sel;
      l_data <= cap_data;
    end else if (bus_start || bus_abort || launch) begin
      st <= PEND_EMPTY;
    end
  end

  // R6: write protect low leaves nothing pending afterwards
  assert_wp_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> st == PEND_EMPTY);

  // R8: START or abort without a new request empties the holder
  assert_start_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_abort) && !cap |=> st == PEND_EMPTY);
endmodule

// File: rtl/nvc_prog_timer.sv
module nvc_prog_timer #(
  parameter int PROG_CYCLES = 500,
  parameter int CH_W        = 2,
  parameter int SEL_W       = 2,
  parameter int DW          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CH_W-1:0]  l_chan,
  input  logic [SEL_W-1:0] l_sel,
  input  logic [DW-1:0]    l_data,
  output logic             busy,
  output logic             commit,
  output logic [CH_W-1:0]  t_chan,
  output logic [SEL_W-1:0] t_sel,
  output logic [DW-1:0]    t_data
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      t_chan <= '0;
      t_sel  <= '0;
      t_data <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      cnt    <= LOAD;
      t_chan <= l_chan;
      t_sel  <= l_sel;
      t_data <= l_data;
    end else if (commit) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R3: a launch always opens a busy period
  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R3: busy never ends early and counts down by one
  assert_no_early_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) |=> busy && (cnt == $past(cnt) - CNT_W'(1)));

  // R3: the commit cycle is the last busy cycle
  assert_commit_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !launch |=> !busy);
endmodule

// File: rtl/nvc_reg_bank.sv
module nvc_reg_bank #(
  parameter int CH  = 4,
  parameter int NVR = 4,
  parameter int DW  = 8,
  localparam int CH_W  = $clog2(CH),
  localparam int SEL_W = $clog2(NVR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vol_we,
  input  logic [CH_W-1:0]  vol_chan,
  input  logic [DW-1:0]    vol_data,
  input  logic             nv_we,
  input  logic [CH_W-1:0]  nv_chan,
  input  logic [SEL_W-1:0] nv_sel,
  input  logic [DW-1:0]    nv_data,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic [CH*DW-1:0] wiper_bus
);
  logic [DW-1:0] nv_q [CH][NVR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CH; c++)
        for (int r = 0; r < NVR; r++)
          nv_q[c][r] <= '0;
    end else if (nv_we) begin
      nv_q[nv_chan][nv_sel] <= nv_data;
    end
  end

  assign rd_data = nv_q[rd_chan][rd_sel];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [DW-1:0] wiper_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                wiper_r <= '0;
      else if (vol_we && vol_chan == CH_W'(c))   wiper_r <= vol_data;
    end

    assign wiper_bus[c*DW +: DW] = wiper_r;

    for (genvar r = 0; r < NVR; r++) begin : g_reg
      // R10: a register changes only when a commit addresses it
      assert_nv_only_on_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_we && nv_chan == CH_W'(c) && nv_sel == SEL_W'(r)) |=> $stable(nv_q[c][r]));
    end
  end
endmodule

// File: rtl/nv_write_ctrl.sv
module nv_write_ctrl #(
  parameter int CH          = 4,
  parameter int NVR         = 4,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 500,
  localparam int CH_W  = $clog2(CH),
  localparam int SEL_W = $clog2(NVR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             bus_abort,
  input  logic             wp_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_nv,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [DW-1:0]    req_data,
  output logic             busy,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic [CH*DW-1:0] wiper_bus
);
  logic             accept, vol_we, cap, launch, commit;
  logic [CH_W-1:0]  l_chan, t_chan;
  logic [SEL_W-1:0] l_sel, t_sel;
  logic [DW-1:0]    l_data, t_data;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign vol_we    = accept && !req_nv;
  assign cap       = accept && req_nv;

  nvc_pending #(.CH_W(CH_W), .SEL_W(SEL_W), .DW(DW)) u_pending (
    .clk, .rst_n, .bus_start, .bus_stop, .bus_abort, .wp_n, .busy,
    .cap, .cap_chan(req_chan), .cap_sel(req_sel), .cap_data(req_data),
    .launch, .l_chan, .l_sel, .l_data
  );

  nvc_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .CH_W(CH_W), .SEL_W(SEL_W), .DW(DW)) u_timer (
    .clk, .rst_n, .launch, .l_chan, .l_sel, .l_data,
    .busy, .commit, .t_chan, .t_sel, .t_data
  );

  nvc_reg_bank #(.CH(CH), .NVR(NVR), .DW(DW)) u_bank (
    .clk, .rst_n,
    .vol_we, .vol_chan(req_chan), .vol_data(req_data),
    .nv_we(commit), .nv_chan(t_chan), .nv_sel(t_sel), .nv_data(t_data),
    .rd_chan, .rd_sel, .rd_data, .wiper_bus
  );

  // R3 / R5: a busy period only ever follows a STOP with write protect high
  assert_busy_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop) && $past(wp_n));

  // R4: nothing is taken from the stream while busy
  assert_no_take_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !commit |=> $stable(wiper_bus));
endmodule

// File: tb/test_nv_write_ctrl.sv
module test_nv_write_ctrl;
  localparam int CH = 4, NVR = 4, DW = 8, P = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, bus_abort = 0, wp_n = 1;
  logic req_valid = 0, req_nv = 0;
  logic [1:0] req_chan = 0, req_sel = 0, rd_chan = 0, rd_sel = 0;
  logic [7:0] req_data = 0, rd_data;
  logic req_ready, busy;
  logic [CH*DW-1:0] wiper_bus;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  nv_write_ctrl #(.CH(CH), .NVR(NVR), .DW(DW), .PROG_CYCLES(P)) i_nv_write_ctrl (
    .clk, .rst_n, .bus_start, .bus_stop, .bus_abort, .wp_n,
    .req_valid, .req_ready, .req_nv, .req_chan, .req_sel, .req_data,
    .busy, .rd_chan, .rd_sel, .rd_data, .wiper_bus
  );

  // vector: {nv, wp mode(0 high,1 low at request,2 pulse low before stop), ch, sel, data, expect write}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd0, 8'h11, 1'b1},
    {1'b0, 2'd1, 2'd3, 2'd0, 8'h2A, 1'b1},
    {1'b1, 2'd0, 2'd1, 2'd2, 8'h5C, 1'b1},
    {1'b1, 2'd0, 2'd3, 2'd0, 8'hA7, 1'b1},
    {1'b1, 2'd1, 2'd2, 2'd1, 8'h33, 1'b0},
    {1'b1, 2'd2, 2'd0, 2'd3, 8'h44, 1'b0},
    {1'b1, 2'd0, 2'd0, 2'd3, 8'hC9, 1'b1},
    {1'b0, 2'd0, 2'd1, 2'd0, 8'hFE, 1'b1}
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic read_nv(input int ch, input int sel, output logic [7:0] v);
    rd_chan = 2'(ch); rd_sel = 2'(sel); #1; v = rd_data;
  endtask

  task automatic pulse_start(); bus_start = 1; step(); bus_start = 0; endtask
  task automatic pulse_stop();  bus_stop = 1;  step(); bus_stop = 0;  endtask
  task automatic pulse_abort(); bus_abort = 1; step(); bus_abort = 0; endtask

  task automatic send(input logic nv, input int ch, input int sel, input logic [7:0] d);
    req_valid = 1; req_nv = nv; req_chan = 2'(ch); req_sel = 2'(sel); req_data = d;
    step();
    req_valid = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; step(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, old;
    int n;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 ready", req_ready, 1);
    check("R11 wipers", wiper_bus, 0);
    read_nv(3, 3, v); check("R11 nv", v, 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic vnv, vexp; logic [1:0] vwp; int ch, sel; logic [7:0] d;
      {vnv, vwp} = {VEC[i][15], VEC[i][14:13]};
      ch = int'(VEC[i][12:11]); sel = int'(VEC[i][10:9]);
      d = VEC[i][8:1]; vexp = VEC[i][0];
      if (vnv) read_nv(ch, sel, old); else old = wiper_bus[ch*DW +: DW];
      pulse_start();
      if (vwp == 2'd1) wp_n = 0;
      send(vnv, ch, sel, d);
      if (!vnv) begin
        check("R1 wiper write", wiper_bus[ch*DW +: DW], d);
        check("R1 no busy", busy, 0);
      end
      if (vwp == 2'd2) begin wp_n = 0; step(); end
      wp_n = 1;
      pulse_stop();
      count_busy(n);
      if (vnv && vexp) begin
        check("R3 busy length", n, P);
        read_nv(ch, sel, v); check("R3 committed", v, d);
      end else if (vnv) begin
        check(vwp == 2'd1 ? "R5 no cycle" : "R6 no cycle", n, 0);
        read_nv(ch, sel, v); check(vwp == 2'd1 ? "R5 unchanged" : "R6 unchanged", v, old);
      end else begin
        check("R1 vol no cycle", n, 0);
      end
    end

    // R2 held until STOP, R3 exact commit edge
    pulse_start();
    send(1, 2, 3, 8'h77);
    repeat (20) step();
    check("R2 busy low before stop", busy, 0);
    read_nv(2, 3, v); check("R2 no early write", v, 0);
    pulse_stop();
    ok = 1;
    for (int k = 0; k < P; k++) begin
      read_nv(2, 3, v);
      if (!busy || v != 8'h00) ok = 0;
      step();
    end
    check("R3 busy held, reg unchanged", ok, 1);
    check("R3 busy fell", busy, 0);
    read_nv(2, 3, v); check("R3 written at fall", v, 8'h77);

    // R4 blocked stream, R7 write protect inside the cycle
    pulse_start();
    send(1, 1, 0, 8'h3C);
    pulse_stop();
    wp_n = 0;
    req_valid = 1; req_nv = 0; req_chan = 1; req_data = 8'h99;
    step();
    check("R4 ready low", req_ready, 0);
    repeat (3) step();
    req_valid = 0;
    count_busy(n);
    wp_n = 1;
    check("R7 full length", n + 4, P);
    read_nv(1, 0, v); check("R7 committed", v, 8'h3C);
    check("R4 wiper untouched", wiper_bus[1*DW +: DW], 8'hFE);

    // R8 second START and abort discard
    pulse_start();
    send(1, 2, 0, 8'h12);
    pulse_start();
    pulse_stop();
    count_busy(n); check("R8 start drop", n, 0);
    pulse_start();
    send(1, 2, 0, 8'h13);
    pulse_abort();
    pulse_stop();
    count_busy(n); check("R8 abort drop", n, 0);
    read_nv(2, 0, v); check("R8 unchanged", v, 0);

    // R9 last write wins
    pulse_start();
    send(1, 3, 1, 8'h01);
    send(1, 3, 2, 8'h02);
    pulse_stop();
    count_busy(n); check("R9 one cycle", n, P);
    read_nv(3, 2, v); check("R9 later target", v, 8'h02);
    read_nv(3, 1, v); check("R9 earlier dropped", v, 0);

    // R6 write protect low in the STOP cycle
    pulse_start();
    send(1, 2, 2, 8'h66);
    wp_n = 0; bus_stop = 1; step(); bus_stop = 0; wp_n = 1;
    count_busy(n); check("R6 stop cycle cancel", n, 0);
    read_nv(2, 2, v); check("R6 stop cycle unchanged", v, 0);

    // R10 neighbours kept
    read_nv(1, 2, v); check("R10 keep 1.2", v, 8'h5C);
    read_nv(3, 0, v); check("R10 keep 3.0", v, 8'hA7);
    read_nv(0, 3, v); check("R10 keep 0.3", v, 8'hC9);
    read_nv(0, 0, v); check("R10 keep 0.0", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule